// File: doc/BRIEF.md
# Packed SIMD Add/Subtract Unit

This block is a purely combinational lane-wise arithmetic unit on a 32-bit word. It adds or subtracts two packed operands and offers plain (wrapping), saturating and halving forms. The lane width and the signedness of the lanes are not carried by the opcode. They are decoded from the register index that accompanies the operation. One index range gives four 8-bit lanes and another gives two 16-bit lanes, and within each range the lower part is signed and the upper part unsigned.

A two-bit opcode picks add, subtract, halving add or halving subtract. A two-bit mode field picks wrapping or saturating results for add and subtract. The unit drives the packed result, a flag that is high when any lane was clamped, and a flag that marks an encoding that cannot be executed. It sits in a decode/execute path that has already read the operands. No state is kept, so the result is valid in the same cycle as its inputs.

Top module: `packed_addsub`

## Requirements
- R1: Index 16..23 selects two signed 16-bit lanes and index 24..29 selects two unsigned 16-bit lanes. Lane 0 occupies bits 15:0 and lane 1 occupies bits 31:16.
- R2: Index 2..7 selects four signed 8-bit lanes and index 8..15 selects four unsigned 8-bit lanes. Lane i occupies bits 8i+7:8i.
- R3: Opcode 00 (add) or 01 (subtract) with mode 00 gives each lane modulo 2^W, where W is the lane width, for any legal index. No carry or borrow crosses a lane boundary, and the overflow flag stays 0.
- R4: Opcode 00 or 01 with mode 01 on a signed range clamps each lane to the interval [-2^(W-1), 2^(W-1)-1].
- R5: Opcode 00 or 01 with mode 01 on an unsigned range clamps each lane to the interval [0, 2^W-1].
- R6: The overflow output is 1 exactly when at least one lane was clamped by a saturating operation. Otherwise it is 0.
- R7: Opcode 10 (halving add) with mode 00 gives floor((a+b)/2) per lane. The operands are read as signed or unsigned according to the range of the index. The result is never clamped.
- R8: Opcode 11 (halving subtract) with mode 00 forms a-b per lane as a (W+1)-bit two's complement value and shifts it right arithmetically by one bit.
- R9: The illegal output is 1 in three cases: the index is 0, 1, 30 or 31; the mode is 10 or 11 on add or subtract; or the mode is not 00 on a halving opcode. While the illegal output is 1, the result is zero and the overflow output is 0.
- R10: All outputs follow the inputs without a clock edge. The block holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 2 | 00 add, 01 subtract, 10 halving add, 11 halving subtract |
| mode_i | input | 2 | 00 wrap or halving, 01 saturate, other values illegal |
| idx_i | input | 5 | Register index; its range selects lane width and signedness |
| opa_i | input | 32 | First packed operand |
| opb_i | input | 32 | Second packed operand (subtrahend) |
| res_o | output | 32 | Packed result, zero when illegal |
| ovf_o | output | 1 | High when any lane saturated |
| illegal_o | output | 1 | High for an index or mode that cannot be executed |

## Verification
Every output is due in the same cycle as its stimulus, with zero register stages. The bench therefore applies each stimulus just after a rising clock edge and samples at the following falling edge. One test also changes an operand between two clock edges and expects the result to follow within a time step. The vector table reaches every index boundary (1/2, 7/8, 15/16, 23/24, 29/30) and the clamp in both directions for each signedness and width. A sweep of all 32 index values checks the width and legality decode.

// File: rtl/packed_addsub.sv
module packed_addsub #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic [1:0]        op_i,
  input  logic [1:0]        mode_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [DATA_W-1:0] res_o,
  output logic              ovf_o,
  output logic              illegal_o
);

  localparam int S8_LO  = 2;
  localparam int U8_LO  = 8;
  localparam int S16_LO = 16;
  localparam int U16_LO = 24;
  localparam int U16_HI = 29;

  int  idx_v;
  logic idx_bad, w16, sgn, sub, half, sat, mode_bad;

  assign idx_v    = int'(idx_i);
  assign idx_bad  = (idx_v < S8_LO) || (idx_v > U16_HI);
  assign w16      = (idx_v >= S16_LO);
  assign sgn      = w16 ? (idx_v < U16_LO) : (idx_v < U8_LO);
  assign sub      = op_i[0];
  assign half     = op_i[1];
  assign mode_bad = half ? (mode_i != 2'b00) : mode_i[1];
  assign sat      = !half && (mode_i == 2'b01);

  logic [DATA_W-1:0] w_res [2];
  logic [1:0]        w_ovf;

  for (genvar gw = 0; gw < 2; gw++) begin : g_w
    localparam int W = (gw == 0) ? 8 : 16;
    localparam int N = DATA_W / W;
    logic [DATA_W-1:0] packed_r;
    logic [N-1:0]      clamp;

    for (genvar l = 0; l < N; l++) begin : g_l
      logic [W-1:0] a, b, r, satv;
      logic [W+1:0] ea, eb, s;
      logic         fits;

      assign a  = opa_i[l*W +: W];
      assign b  = opb_i[l*W +: W];
      assign ea = sgn ? {{2{a[W-1]}}, a} : {2'b00, a};
      assign eb = sgn ? {{2{b[W-1]}}, b} : {2'b00, b};
      assign s  = sub ? (ea - eb) : (ea + eb);

      assign fits = sgn ? ((s[W+1:W-1] == 3'b000) || (s[W+1:W-1] == 3'b111))
                        : (s[W+1:W] == 2'b00);
      assign clamp[l] = sat && !fits;

      assign satv = sgn ? (s[W+1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}})
                        : (s[W+1] ? {W{1'b0}} : {W{1'b1}});

      assign r = half ? s[W:1] : (clamp[l] ? satv : s[W-1:0]);
      assign packed_r[l*W +: W] = r;
    end

    assign w_res[gw] = packed_r;
    assign w_ovf[gw] = |clamp;
  end

  assign illegal_o = idx_bad || mode_bad;
  assign res_o     = illegal_o ? '0 : (w16 ? w_res[1] : w_res[0]);
  assign ovf_o     = !illegal_o && (w16 ? w_ovf[1] : w_ovf[0]);

  always_comb begin
    if (illegal_o) begin
      AST_ILLEGAL_ZERO: assert (res_o == '0 && !ovf_o) else $error("illegal result not quiet"); // R9
    end
    if (ovf_o) begin
      AST_OVF_ONLY_SAT: assert (mode_i == 2'b01 && !op_i[1]) else $error("overflow outside saturation"); // R6
    end
    if (!illegal_o) begin
      AST_LEGAL_RANGE: assert (int'(idx_i) >= S8_LO && int'(idx_i) <= U16_HI) else $error("index accepted out of range"); // R1
    end
    if (!illegal_o && op_i == 2'b00 && mode_i == 2'b00 && int'(idx_i) >= S16_LO) begin
      AST_WRAP_LANE0: assert (res_o[15:0] == 16'(opa_i[15:0] + opb_i[15:0])) else $error("wrap lane 0 mismatch"); // R3
    end
  end

endmodule

// File: tb/test_packed_addsub.sv
module test_packed_addsub;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0]  op, mode;
  logic [4:0]  idx;
  logic [31:0] a, b, res;
  logic        ovf, ill;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  packed_addsub i_packed_addsub (
    .op_i(op), .mode_i(mode), .idx_i(idx), .opa_i(a), .opb_i(b),
    .res_o(res), .ovf_o(ovf), .illegal_o(ill)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic [1:0]  op;
    logic [1:0]  mode;
    logic [4:0]  idx;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] r;
    logic        o;
    logic        i;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{4'd3, 2'd0, 2'd0, 5'd20, 32'h7FFF_FFFF, 32'h0001_0001, 32'h8000_0000, 1'b0, 1'b0}, // R3
    '{4'd3, 2'd1, 2'd0, 5'd10, 32'h0010_80FF, 32'h0101_0101, 32'hFF0F_7FFE, 1'b0, 1'b0}, // R3
    '{4'd3, 2'd1, 2'd0, 5'd28, 32'h0000_0000, 32'h0001_0001, 32'hFFFF_FFFF, 1'b0, 1'b0}, // R3
    '{4'd3, 2'd0, 2'd0, 5'd6,  32'hFFFF_FFFF, 32'h0101_0101, 32'h0000_0000, 1'b0, 1'b0}, // R3
    '{4'd4, 2'd0, 2'd1, 5'd16, 32'h7FFF_8000, 32'h0001_FFFF, 32'h7FFF_8000, 1'b1, 1'b0}, // R4
    '{4'd4, 2'd1, 2'd1, 5'd5,  32'h807F_1005, 32'h01FF_2003, 32'h807F_F002, 1'b1, 1'b0}, // R4
    '{4'd5, 2'd0, 2'd1, 5'd27, 32'hFFF0_1234, 32'h0020_0001, 32'hFFFF_1235, 1'b1, 1'b0}, // R5
    '{4'd5, 2'd1, 2'd1, 5'd12, 32'h0510_FF00, 32'h0610_0100, 32'h0000_FE00, 1'b1, 1'b0}, // R5
    '{4'd6, 2'd0, 2'd1, 5'd18, 32'h0001_0002, 32'h0003_0004, 32'h0004_0006, 1'b0, 1'b0}, // R6
    '{4'd7, 2'd2, 2'd0, 5'd22, 32'h7FFF_FFFF, 32'h7FFF_FFFE, 32'h7FFF_FFFE, 1'b0, 1'b0}, // R7
    '{4'd7, 2'd2, 2'd0, 5'd9,  32'hFF01_8003, 32'hFF00_8004, 32'hFF00_8003, 1'b0, 1'b0}, // R7
    '{4'd8, 2'd3, 2'd0, 5'd3,  32'h807F_0005, 32'h7F80_0102, 32'h807F_FF01, 1'b0, 1'b0}, // R8
    '{4'd8, 2'd3, 2'd0, 5'd25, 32'h0000_FFFF, 32'h0001_0001, 32'hFFFF_7FFF, 1'b0, 1'b0}, // R8
    '{4'd9, 2'd0, 2'd0, 5'd30, 32'h0000_0001, 32'h0000_0001, 32'h0000_0000, 1'b0, 1'b1}, // R9
    '{4'd9, 2'd0, 2'd0, 5'd1,  32'h0000_0001, 32'h0000_0001, 32'h0000_0000, 1'b0, 1'b1}, // R9
    '{4'd9, 2'd0, 2'd2, 5'd20, 32'h7FFF_0000, 32'h0001_0000, 32'h0000_0000, 1'b0, 1'b1}, // R9
    '{4'd9, 2'd2, 2'd1, 5'd5,  32'h0102_0304, 32'h0101_0101, 32'h0000_0000, 1'b0, 1'b1}, // R9
    '{4'd9, 2'd1, 2'd3, 5'd12, 32'h0510_FF00, 32'h0610_0100, 32'h0000_0000, 1'b0, 1'b1}, // R9
    '{4'd1, 2'd0, 2'd1, 5'd29, 32'h8000_0001, 32'h8000_0001, 32'hFFFF_0002, 1'b1, 1'b0}, // R1
    '{4'd1, 2'd0, 2'd1, 5'd23, 32'h8000_0001, 32'h8000_0001, 32'h8000_0002, 1'b1, 1'b0}, // R1
    '{4'd2, 2'd0, 2'd1, 5'd15, 32'h8080_8080, 32'h8080_8080, 32'hFFFF_FFFF, 1'b1, 1'b0}, // R2
    '{4'd2, 2'd0, 2'd1, 5'd7,  32'h8080_8080, 32'h8080_8080, 32'h8080_8080, 1'b1, 1'b0}, // R2
    '{4'd2, 2'd1, 2'd1, 5'd2,  32'h0000_0000, 32'h8080_8080, 32'h7F7F_7F7F, 1'b1, 1'b0}, // R2
    '{4'd2, 2'd1, 2'd1, 5'd8,  32'h0000_0000, 32'h8080_8080, 32'h0000_0000, 1'b1, 1'b0}  // R2
  };

  task automatic check(input int rq, input logic [31:0] er, input logic eo, input logic ei);
    total++;
    if (res !== er || ovf !== eo || ill !== ei) begin
      bad++;
      $display("FAIL R%0d idx=%0d op=%0d mode=%0d: res=%h ovf=%b ill=%b, expected res=%h ovf=%b ill=%b",
               rq, idx, op, mode, res, ovf, ill, er, eo, ei);
    end
  endtask

  task automatic apply(input logic [1:0] o, input logic [1:0] m, input logic [4:0] x,
                       input logic [31:0] va, input logic [31:0] vb);
    @(posedge clk);
    op = o; mode = m; idx = x; a = va; b = vb;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R10 watchdog expired: cycles=%0d expected completion earlier", WD_CYCLES);
    finish_run();
  end

  initial begin
    op = '0; mode = '0; idx = '0; a = '0; b = '0;
    repeat (3) @(negedge clk);
    // reset state: all-zero inputs give index 0, which is illegal (R9)
    check(9, 32'h0, 1'b0, 1'b1);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      apply(VECS[k].op, VECS[k].mode, VECS[k].idx, VECS[k].a, VECS[k].b);
      check(int'(VECS[k].rq), VECS[k].r, VECS[k].o, VECS[k].i);
    end

    // width and legality sweep over every index: R1 for 16-bit, R2 for 8-bit
    for (int x = 0; x < 32; x++) begin
      apply(2'd0, 2'd0, 5'(x), 32'h00FF_00FF, 32'h0001_0001);
      if (x < 2 || x > 29) check(9, 32'h0, 1'b0, 1'b1);
      else if (x < 16)     check(2, 32'h0000_0000, 1'b0, 1'b0);
      else                 check(1, 32'h0100_0100, 1'b0, 1'b0);
    end

    // R10: the result follows an operand change between clock edges
    apply(2'd0, 2'd0, 5'd20, 32'h0000_0001, 32'h0000_0002);
    check(10, 32'h0000_0003, 1'b0, 1'b0);
    b = 32'h0000_0005;
    #1;
    check(10, 32'h0000_0006, 1'b0, 1'b0);
    mode = 2'b01; idx = 5'd5; a = 32'h7F00_0000; b = 32'h0100_0000;
    #1;
    check(4, 32'h7F00_0000, 1'b1, 1'b0);

    finish_run();
  end

endmodule